// File: doc/BRIEF.md
# Prioritised Interrupt Level Aggregator

This block gathers thirteen fixed interrupt request lines into a 32-bit pending register, gates them with a 32-bit enable register, and reduces what remains to a 3-bit processor priority level together with an autovector number. Every request line owns one fixed bit of the pending register. Every line also belongs to one of three priority groups: level 3, level 5 or level 6.

A request line changes its pending bit only on a transition. A low-to-high transition sets the bit and a high-to-low transition clears it. While a line stays steady, software can overwrite the pending register freely. Both registers are read and written as whole 32-bit words through a simple single-cycle register port. There is no streaming data path, so all pins are plain control and status signals with no back-pressure.

The level output names the highest group that has at least one bit both pending and enabled. The vector output gives that group's autovector number. Both outputs are registered.

Top module: `irqagg_top`

## Requirements
- R1: Line indices 0..6 (floppy, keyboard, power, net-receive, net-transmit, disk controller, timer) own pending bits 7, 3, 2, 9, 10, 12 and 5 respectively, and belong to level 3.
- R2: Line index 7 (serial controller) owns pending bit 17 and belongs to level 5.
- R3: Line indices 8..12 (net-transmit DMA, net-receive DMA, disk DMA, sound, serial DMA) own pending bits 28, 27, 26, 23 and 21 respectively, and belong to level 6.
- R4: `vec` is 27 while `ipl` is 3, 29 while `ipl` is 5, 30 while `ipl` is 6, and 0 while `ipl` is 0.
- R5: A line seen high at a clock edge after being low at the previous edge sets its pending bit at that edge. A line seen low after being high clears it. A steady line leaves the bit as it is. `ipl` and `vec` follow one edge after the pending register.
- R6: A write with `bus_addr` = 0x7000 loads the pending register, and a write with `bus_addr` = 0x7800 loads the enable register. `bus_rdata` shows the addressed register at those two offsets. Any other address reads 0, and a write to it changes neither register.
- R7: A pending bit contributes to `ipl` only when the enable bit at the same position is 1.
- R8: `ipl` is the highest of 3, 5 and 6 whose group has an enabled pending bit, and 0 when no group has one.
- R9: When a pending-register write and a line transition fall on the same edge, the written word is what the register holds afterwards.
- R10: After reset, the pending register, the enable register, `ipl` and `vec` are all 0.
- R11: Pending bits that no line owns can be written and read back, but they never raise `ipl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 13 | Request lines, index order as in R1-style listing |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 16 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ipl | output | 3 | Processor priority level (0, 3, 5 or 6) |
| vec | output | 8 | Autovector number for `ipl` |

## Verification
The assertions assume that `irq_lines`, `bus_wr`, `bus_addr` and `bus_wdata` are synchronous to `clk` and hold known values at every edge after reset. The transition checks read a line's previous sampled value as the design's own history of that line. The bench meets this by changing every input a fixed 2 ns after a rising edge, never near the edge. It keeps the lines steady whenever it writes the pending register, except in the deliberate same-edge collision case.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int DATA_W  = 32;
  localparam int NUM_SRC = 13;
  localparam int NUM_LVL = 3;
  localparam int IPL_W   = 3;
  localparam int VEC_W   = 8;

  typedef logic [DATA_W-1:0] word_t;

  // pending-bit position owned by each request line
  function automatic int src_bit(input int idx);
    case (idx)
      0:  return 7;
      1:  return 3;
      2:  return 2;
      3:  return 9;
      4:  return 10;
      5:  return 12;
      6:  return 5;
      7:  return 17;
      8:  return 28;
      9:  return 27;
      10: return 26;
      11: return 23;
      default: return 21;
    endcase
  endfunction

  // priority level requested by each line
  function automatic int src_lvl(input int idx);
    if (idx < 7)       return 3;
    else if (idx == 7) return 5;
    else               return 6;
  endfunction

  // group index -> processor level, ascending
  function automatic int lvl_code(input int g);
    case (g)
      0:       return 3;
      1:       return 5;
      default: return 6;
    endcase
  endfunction

  function automatic int lvl_vec(input int g);
    case (g)
      0:       return 27;
      1:       return 29;
      default: return 30;
    endcase
  endfunction

  function automatic word_t lvl_bits(input int g);
    word_t m;
    m = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (src_lvl(i) == lvl_code(g)) m[src_bit(i)] = 1'b1;
    return m;
  endfunction

  function automatic word_t owned_bits();
    word_t m;
    m = '0;
    for (int i = 0; i < NUM_SRC; i++) m[src_bit(i)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irqagg_src_edge.sv
module irqagg_src_edge
  import irqagg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] lines,
  output word_t              set_bits,
  output word_t              clr_bits
);
  logic [NUM_SRC-1:0] lines_q;
  logic [NUM_SRC-1:0] up, down;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lines_q <= '0;
    else        lines_q <= lines;
  end

  assign up   = lines & ~lines_q;
  assign down = ~lines & lines_q;

  // scatter per-line transitions onto their owned pending bits
  always_comb begin
    set_bits = '0;
    clr_bits = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      set_bits[src_bit(i)] = up[i];
      clr_bits[src_bit(i)] = down[i];
    end
  end
endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
  import irqagg_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] STATUS_OFF = 16'h7000,
  parameter logic [ADDR_W-1:0] MASK_OFF   = 16'h7800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  word_t             set_bits,
  input  word_t             clr_bits,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  word_t             bus_wdata,
  output word_t             bus_rdata,
  output word_t             pend_q,
  output word_t             enab_q
);
  logic  hit_pend, hit_enab;
  word_t pend_d;

  assign hit_pend = (bus_addr == STATUS_OFF);
  assign hit_enab = (bus_addr == MASK_OFF);

  // hardware transitions first, software write overrides
  always_comb begin
    pend_d = (pend_q | set_bits) & ~clr_bits;
    if (bus_wr && hit_pend) pend_d = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      enab_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (bus_wr && hit_enab) enab_q <= bus_wdata;
    end
  end

  always_comb begin
    if (hit_pend)      bus_rdata = pend_q;
    else if (hit_enab) bus_rdata = enab_q;
    else               bus_rdata = '0;
  end
endmodule

// File: rtl/irqagg_level_enc.sv
module irqagg_level_enc
  import irqagg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  word_t            pend,
  input  word_t            enab,
  output logic [IPL_W-1:0] ipl,
  output logic [VEC_W-1:0] vec
);
  word_t              live;
  logic [NUM_LVL-1:0] grp_hit;
  logic [IPL_W-1:0]   ipl_d;
  logic [VEC_W-1:0]   vec_d;

  assign live = pend & enab;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_grp
    localparam word_t GBITS = lvl_bits(g);
    assign grp_hit[g] = |(live & GBITS);
  end

  // groups are ordered by ascending level: last hit wins
  always_comb begin
    ipl_d = '0;
    vec_d = '0;
    for (int g = 0; g < NUM_LVL; g++) begin
      if (grp_hit[g]) begin
        ipl_d = IPL_W'(lvl_code(g));
        vec_d = VEC_W'(lvl_vec(g));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ipl <= '0;
      vec <= '0;
    end else begin
      ipl <= ipl_d;
      vec <= vec_d;
    end
  end
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
  import irqagg_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] STATUS_OFF = 16'h7000,
  parameter logic [ADDR_W-1:0] MASK_OFF   = 16'h7800
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_lines,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [IPL_W-1:0]   ipl,
  output logic [VEC_W-1:0]   vec
);
  word_t set_bits, clr_bits;
  word_t status_q, mask_q;

  irqagg_src_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .lines    (irq_lines),
    .set_bits (set_bits),
    .clr_bits (clr_bits)
  );

  irqagg_regs #(
    .ADDR_W     (ADDR_W),
    .STATUS_OFF (STATUS_OFF),
    .MASK_OFF   (MASK_OFF)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_bits  (set_bits),
    .clr_bits  (clr_bits),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pend_q    (status_q),
    .enab_q    (mask_q)
  );

  irqagg_level_enc u_enc (
    .clk   (clk),
    .rst_n (rst_n),
    .pend  (status_q),
    .enab  (mask_q),
    .ipl   (ipl),
    .vec   (vec)
  );
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk
  import irqagg_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] STATUS_OFF = 16'h7000
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] irq_lines,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  status,
  input logic [DATA_W-1:0]  mask,
  input logic [IPL_W-1:0]   ipl,
  input logic [VEC_W-1:0]   vec
);
  localparam word_t OWNED = owned_bits();
  logic pend_wr;
  assign pend_wr = bus_wr && (bus_addr == STATUS_OFF);

  p_ipl_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ipl == 3'd0) || (ipl == 3'd3) || (ipl == 3'd5) || (ipl == 3'd6));

  p_vec_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((ipl == 3'd0) -> (vec == 8'd0)) && ((ipl == 3'd3) -> (vec == 8'd27)) &&
    ((ipl == 3'd5) -> (vec == 8'd29)) && ((ipl == 3'd6) -> (vec == 8'd30)));

  p_idle_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & mask & OWNED) == '0) |=> (ipl == 3'd0));

  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_wr |=> (status == $past(bus_wdata)));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int B = src_bit(i);
    p_rise_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(irq_lines[i]) && !pend_wr) |-> ##0 1'b1 ##1 status[B]);
    p_fall_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(irq_lines[i]) && !pend_wr) |=> !status[B]);
  end
endmodule

bind irqagg_top irqagg_chk #(
  .ADDR_W     (ADDR_W),
  .STATUS_OFF (STATUS_OFF)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_lines (irq_lines),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .status    (status_q),
  .mask      (mask_q),
  .ipl       (ipl),
  .vec       (vec)
);

// File: tb/tb_irqagg_top.sv
module tb_irqagg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] irq_lines = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_addr = 16'h7000;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  ipl;
  logic [7:0]  vec;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [15:0] A_ST = 16'h7000;
  localparam logic [15:0] A_MK = 16'h7800;

  int bits_tab [13] = '{7, 3, 2, 9, 10, 12, 5, 17, 28, 27, 26, 23, 21};
  int lvl_tab  [13] = '{3, 3, 3, 3, 3, 3, 3, 5, 6, 6, 6, 6, 6};

  irqagg_top dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_lines (irq_lines),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ipl       (ipl),
    .vec       (vec)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] owned();
    logic [31:0] m = '0;
    for (int i = 0; i < 13; i++) m[bits_tab[i]] = 1'b1;
    return m;
  endfunction

  function automatic int exp_lvl(input logic [31:0] st, input logic [31:0] mk);
    int l = 0;
    for (int i = 0; i < 13; i++)
      if (st[bits_tab[i]] && mk[bits_tab[i]] && lvl_tab[i] > l) l = lvl_tab[i];
    return l;
  endfunction

  function automatic int exp_vec(input int l);
    return (l == 3) ? 27 : (l == 5) ? 29 : (l == 6) ? 30 : 0;
  endfunction

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic chk_out(input string tag, input int l);
    check({tag, " ipl"}, 32'(ipl), 32'(l));
    check({tag, " vec R4"}, 32'(vec), 32'(exp_vec(l)));
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] unowned;
    unowned = ~owned();
    step(); step();
    rst_n = 1'b1;
    step();

    // R10 reset state
    rd(A_ST, d); check("R10 status", d, 0);
    rd(A_MK, d); check("R10 mask", d, 0);
    chk_out("R10", 0);

    // R6 mask write and read back
    wr(A_MK, 32'hFFFF_FFFF);
    rd(A_MK, d); check("R6 mask readback", d, 32'hFFFF_FFFF);

    // R1 R2 R3 R5: each line alone
    for (int i = 0; i < 13; i++) begin
      irq_lines = 13'(1 << i);
      step();
      rd(A_ST, d);
      check($sformatf("R1/R2/R3 line %0d bit", i), d, 32'(1) << bits_tab[i]);
      step();
      chk_out($sformatf("R5 line %0d level", i), lvl_tab[i]);
      step();
      rd(A_ST, d);
      check($sformatf("R5 line %0d steady hold", i), d, 32'(1) << bits_tab[i]);
      irq_lines = '0;
      step();
      rd(A_ST, d); check($sformatf("R5 line %0d fall clear", i), d, 0);
      step();
      chk_out($sformatf("R5 line %0d idle", i), 0);
    end

    // R8 priority over all group combinations
    for (int c = 0; c < 8; c++) begin
      int l;
      irq_lines = '0;
      irq_lines[0] = c[0];
      irq_lines[7] = c[1];
      irq_lines[8] = c[2];
      l = c[2] ? 6 : c[1] ? 5 : c[0] ? 3 : 0;
      step(); step();
      chk_out($sformatf("R8 combo %0d", c), l);
      irq_lines = '0;
      step(); step();
    end

    // R7 masking: all lines pending, one enable bit at a time
    irq_lines = '1;
    step();
    rd(A_ST, d); check("R5 all lines", d, owned());
    for (int i = 0; i < 13; i++) begin
      wr(A_MK, 32'(1) << bits_tab[i]);
      step();
      chk_out($sformatf("R7 enable only line %0d", i), exp_lvl(owned(), 32'(1) << bits_tab[i]));
    end
    wr(A_MK, ~owned());
    step();
    chk_out("R7 owned bits disabled", 0);
    wr(A_MK, 32'h0400_1000);
    step();
    chk_out("R7 partial mask", exp_lvl(owned(), 32'h0400_1000));

    // R6 pending write with steady lines
    wr(A_MK, 32'hFFFF_FFFF);
    wr(A_ST, 32'h0002_0080);
    rd(A_ST, d); check("R6 status write", d, 32'h0002_0080);
    step();
    chk_out("R6 level from written status", 5);

    // R9 write collides with falling lines
    irq_lines = '0;
    wr(A_ST, 32'hFFFF_FFFF);
    rd(A_ST, d); check("R9 write beats fall", d, 32'hFFFF_FFFF);
    // R9 write collides with a rising line
    irq_lines[0] = 1'b1;
    wr(A_ST, 32'h0);
    rd(A_ST, d); check("R9 write beats rise", d, 0);
    step();
    rd(A_ST, d); check("R9 steady line after write", d, 0);
    irq_lines = '0;
    step();

    // R11 unowned bits store but never raise a level
    wr(A_ST, unowned);
    rd(A_ST, d); check("R11 unowned readback", d, unowned);
    step();
    chk_out("R11 unowned level", 0);

    // R6 other address: write ignored, read zero
    wr(16'h7004, 32'h1234_5678);
    rd(16'h7004, d); check("R6 other addr read", d, 0);
    rd(A_ST, d); check("R6 other addr status kept", d, unowned);
    rd(A_MK, d); check("R6 other addr mask kept", d, 32'hFFFF_FFFF);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule